// File: doc/BRIEF.md
# Thermistor Derating and Shutdown Tracker

This block watches the temperature of an LED driver through a conductance code from a resistance-tracking converter on an external thermistor network. A higher code means a lower network resistance, so a hotter board. One code step is 250 nS of conductance, and code 256 would be about 15.625 kΩ. Each new code arrives with a one-cycle valid strobe. The block passes it through two first-order low-pass stages that advance only on that strobe. The slow stage, with a time constant of roughly two seconds at the intended strobe rate, sets the current-scale factor applied to the dim level. The fast stage removes noise and drives a thermal-shutdown flag with hysteresis.

The thresholds are conductance codes. Code 197 (about 20.3 kΩ, 95 °C) is where derating begins. Code 246 (about 16.26 kΩ, 125 °C) is where the output is shut off. The output comes back once the code falls below 208 (about 19.23 kΩ, 110 °C). The shutdown does not latch. A start-up permit stays low after reset and holds the rest of the system off until the first temperature reading shows the board cooler than the recovery point. Once granted, the permit stays high.

Top module: `therm_derate`

## Requirements
- R1: After reset, `scale` is 255, `thermal_off` is 0 and `start_ok` is 0.
- R2: The first strobe after reset loads each filter stage with the sample. The fast stage is an accumulator A with K_FAST=2 fraction bits. Each later strobe computes A = A - (A>>2) + code. The fast value is A>>2.
- R3: The slow stage follows the same rule with K_SLOW=6 fraction bits, giving slow value S. For 197 < S < 246, `scale` = 255 - ((S-197)*127)/49, using integer division.
- R4: When S <= 197, `scale` is 255 (full current).
- R5: When S >= 246, `scale` is 128 (half current). `scale` never goes below 128.
- R6: `thermal_off` rises on the clock after a strobe that leaves the fast value at 246 or more.
- R7: Once set, `thermal_off` stays high while the fast value is 208 or more. It clears on the clock after a strobe that leaves the fast value below 208.
- R8: `start_ok` rises on the clock after the first strobe that leaves the fast value below 208. After that it never falls.
- R9: Clock cycles without a strobe change none of the outputs, whatever `code` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| code_vld | input | 1 | One-cycle strobe marking a new conductance code |
| code | input | 8 | Conductance code; larger means hotter |
| scale | output | 8 | Current-scale factor, 255 = full, 128 = half |
| thermal_off | output | 1 | Thermal shutdown request |
| start_ok | output | 1 | Start-up permit, sticky once set |

## Verification
The bench starts a run while the board is hot. A permit that does not wait for a cool reading would release the system into a shutdown. It then holds the fast value between the recovery and shutdown codes. A design without hysteresis would toggle the shutdown flag there. It drives the slow value across both derate corners: an off-by-one at 197 or 246, or a wrong slope, shows up directly in `scale`. It also changes `code` with no strobe present, which would move a filter that samples without qualification. Finally it checks that the first sample primes both stages, because a stage starting from zero would report a cold board for many strobes.

// File: rtl/therm_derate.sv
module therm_derate #(
  parameter int CW           = 8,
  parameter int K_FAST       = 2,
  parameter int K_SLOW       = 6,
  parameter int DERATE_CODE  = 197,
  parameter int SHUT_CODE    = 246,
  parameter int RECOVER_CODE = 208
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          code_vld,
  input  logic [CW-1:0] code,
  output logic [7:0]    scale,
  output logic          thermal_off,
  output logic          start_ok
);
  localparam int FULL = 255;
  localparam int HALF = 128;
  localparam int SPAN = SHUT_CODE - DERATE_CODE;
  localparam int DROP = FULL - HALF;
  localparam int FW   = CW + K_FAST;
  localparam int SWD  = CW + K_SLOW;

  logic [FW-1:0]  acc_f;
  logic [SWD-1:0] acc_s;
  logic           primed;
  logic [CW-1:0]  fast_val, slow_val;
  logic [31:0]    excess, drop_amt;

  assign fast_val = acc_f[FW-1:K_FAST];
  assign slow_val = acc_s[SWD-1:K_SLOW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_f  <= '0;
      acc_s  <= '0;
      primed <= 1'b0;
    end else if (code_vld) begin
      primed <= 1'b1;
      if (!primed) begin
        acc_f <= {code, {K_FAST{1'b0}}};
        acc_s <= {code, {K_SLOW{1'b0}}};
      end else begin
        acc_f <= acc_f - (acc_f >> K_FAST) + {{K_FAST{1'b0}}, code};
        acc_s <= acc_s - (acc_s >> K_SLOW) + {{K_SLOW{1'b0}}, code};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thermal_off <= 1'b0;
      start_ok    <= 1'b0;
    end else begin
      if (thermal_off)
        thermal_off <= (32'(fast_val) >= 32'(RECOVER_CODE));
      else
        thermal_off <= primed && (32'(fast_val) >= 32'(SHUT_CODE));
      if (primed && (32'(fast_val) < 32'(RECOVER_CODE)))
        start_ok <= 1'b1;
    end
  end

  assign excess   = 32'(slow_val) - 32'(DERATE_CODE);
  assign drop_amt = (excess * 32'(DROP)) / 32'(SPAN);

  always_comb begin
    if (32'(slow_val) <= 32'(DERATE_CODE))
      scale = 8'(FULL);
    else if (32'(slow_val) >= 32'(SHUT_CODE))
      scale = 8'(HALF);
    else
      scale = 8'(32'(FULL) - drop_amt);
  end
endmodule

module therm_derate_chk #(
  parameter int CW           = 8,
  parameter int RECOVER_CODE = 208,
  parameter int SHUT_CODE    = 246
) (
  input logic          clk,
  input logic          rst_n,
  input logic          code_vld,
  input logic [CW-1:0] fv,
  input logic [CW-1:0] sv,
  input logic [7:0]    scale,
  input logic          thermal_off,
  input logic          start_ok
);
  a_r6_rise_only_hot: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(thermal_off) |-> (32'($past(fv)) >= 32'(SHUT_CODE)));
  a_r7_clear_only_cool: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(thermal_off) |-> (32'($past(fv)) < 32'(RECOVER_CODE)));
  a_r8_permit_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> start_ok);
  a_r5_scale_floor: assert property (@(posedge clk) disable iff (!rst_n)
    scale >= 8'd128);
  a_r9_hold_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !code_vld |=> ($stable(fv) && $stable(sv)));
endmodule

bind therm_derate therm_derate_chk #(
  .CW(CW), .RECOVER_CODE(RECOVER_CODE), .SHUT_CODE(SHUT_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .code_vld(code_vld), .fv(fast_val), .sv(slow_val),
  .scale(scale), .thermal_off(thermal_off), .start_ok(start_ok)
);

// File: tb/therm_derate_test.sv
module therm_derate_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       code_vld = 1'b0;
  logic [7:0] code = 8'd0;
  logic [7:0] scale;
  logic       thermal_off, start_ok;

  int total = 0, bad = 0;
  int af = 0, as_ = 0, m_primed = 0, m_shut = 0, m_go = 0;
  bit finished = 1'b0;

  therm_derate uut (.clk(clk), .rst_n(rst_n), .code_vld(code_vld), .code(code),
                    .scale(scale), .thermal_off(thermal_off), .start_ok(start_ok));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int exp_scale(int sv);
    if (sv <= 197) return 255;
    if (sv >= 246) return 128;
    return 255 - ((sv - 197) * 127) / 49;
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_all();
    int sv = as_ >> 6;
    check(sv <= 197 ? "R4 scale full" : (sv >= 246 ? "R5 scale floor" : "R3 scale slope"),
          int'(scale), exp_scale(sv));
    check(m_shut != 0 ? "R6 shutdown" : "R7 shutdown clear", int'(thermal_off), m_shut);
    check("R8 start permit", int'(start_ok), m_go);
  endtask

  task automatic sample(int c);
    int fv;
    @(negedge clk);
    code = 8'(c); code_vld = 1'b1;
    @(negedge clk);
    code_vld = 1'b0; code = 8'($urandom_range(0, 255));
    @(negedge clk);
    if (m_primed == 0) begin
      af = c << 2; as_ = c << 6; m_primed = 1;
    end else begin
      af = af - (af >> 2) + c;
      as_ = as_ - (as_ >> 6) + c;
    end
    fv = af >> 2;
    if (m_shut != 0) m_shut = (fv >= 208) ? 1 : 0;
    else m_shut = (fv >= 246) ? 1 : 0;
    if (fv < 208) m_go = 1;
    check_all();
  endtask

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 scale", int'(scale), 255);
    check("R1 shutdown", int'(thermal_off), 0);
    check("R1 permit", int'(start_ok), 0);
    // R2 priming: a single hot first sample trips shutdown at once
    sample(250);
    check("R2 primed fast stage", int'(thermal_off), 1);
    check("R2 primed slow stage", int'(scale), 128);
    repeat (6) sample(250);
    check("R8 permit held while hot", int'(start_ok), 0);
    // R7 hysteresis band
    repeat (10) sample(220);
    check("R7 held in band", int'(thermal_off), 1);
    repeat (10) sample(150);
    check("R7 released", int'(thermal_off), 0);
    check("R8 permit granted", int'(start_ok), 1);
    // R9 no strobe: code wiggles, outputs hold
    begin
      logic [7:0] s0; logic t0, g0;
      s0 = scale; t0 = thermal_off; g0 = start_ok;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk); code = 8'($urandom_range(0, 255));
      end
      @(negedge clk);
      check("R9 scale stable", int'(scale), int'(s0));
      check("R9 shutdown stable", int'(thermal_off), int'(t0));
      check("R9 permit stable", int'(start_ok), int'(g0));
    end
    // R3 R4 R5 random walks across both derate corners
    for (int k = 0; k < 60; k++) begin
      int lo, hi, n;
      case ($urandom_range(0, 3))
        0: begin lo = 0;   hi = 196; end
        1: begin lo = 190; hi = 215; end
        2: begin lo = 235; hi = 255; end
        default: begin lo = 0; hi = 255; end
      endcase
      n = $urandom_range(1, 25);
      for (int j = 0; j < n; j++) sample($urandom_range(lo, hi));
    end
    repeat (300) sample(255);
    repeat (300) sample(197);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule